// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Timing Layer

This block is the signalling layer of a slave on a single-wire, open-drain bus. The master starts every time slot by pulling the line low, and the slave times each slot from that falling edge. The block takes the raw line level and drives a pull-down enable for the pad. It turns master write slots into received bits. In read slots it drives a bit supplied by the layer above. It spots reset pulses and answers each one with a presence pulse. All delays are counted in microseconds, using a tick derived from the parameter `CYC_PER_US` (clock cycles per microsecond).

The input passes through a two-flop synchroniser and then a level filter. The filter accepts a new level only after it has held for one microsecond. A controller, `ow_slot_fsm`, owns the slot timing. Its states are:

| State | Role |
|---|---|
| `S_IDLE` | Waits for a falling edge. |
| `S_SLOT_LOW` | Write slot: waits for the sample point. |
| `S_READ_HOLD` | Read slot with a 0: pulls the line low. |
| `S_SLOT_WAIT` | Waits for the line to return high and watches the reset limit. |
| `S_RST_HIGH` | Reset seen: waits for the master to release the line. |
| `S_PRES_WAIT` | Delay before the presence pulse. |
| `S_PRES_DRIVE` | Drives the presence pulse. |

Its transitions are:

| From | To | Condition |
|---|---|---|
| `S_IDLE` | `S_SLOT_LOW` | Falling edge with `tx_mode`=0. |
| `S_IDLE` | `S_READ_HOLD` | Falling edge with `tx_mode`=1 and `tx_bit`=0. |
| `S_IDLE` | `S_SLOT_WAIT` | Falling edge with `tx_mode`=1 and `tx_bit`=1. |
| `S_SLOT_LOW` | `S_SLOT_WAIT` | Sample point reached, at 30 µs. |
| `S_READ_HOLD` | `S_SLOT_WAIT` | 0-bit hold ends, at 30 µs. |
| `S_SLOT_WAIT` | `S_IDLE` | Line high. |
| `S_SLOT_WAIT` | `S_RST_HIGH` | 480 µs counted since the falling edge. |
| `S_RST_HIGH` | `S_PRES_WAIT` | Line high. |
| `S_PRES_WAIT` | `S_PRES_DRIVE` | 30 µs elapsed. |
| `S_PRES_DRIVE` | `S_IDLE` | 120 µs elapsed. |

Top module: `ow_slave_phy`

## Requirements
- R1: After reset, `pull_low` is 0 and none of `rx_valid`, `tx_request` or `reset_detected` pulses while the line stays high.
- R2: A low on `line_in` that lasts less than 1 µs causes no strobe and no pull-down.
- R3: A low lasting at least 480 µs, counted from its falling edge, produces exactly one `reset_detected` pulse, issued while the line is still low.
- R4: After the line rises at the end of a reset, `pull_low` is asserted 15 to 60 µs later and held for 60 to 240 µs (design point: 30 µs and 120 µs).
- R5: When `tx_mode`=0, each slot gives exactly one `rx_valid`. The line is sampled 30 µs after the filtered falling edge. `rx_bit`=1 when the master held the line low for 15 µs or less, and `rx_bit`=0 when it held it low for 60 µs or more.
- R6: In a slot that starts with `tx_mode`=1 and `tx_bit`=0, the block pulls the line low. The line therefore reads 0 at 20 µs after the falling edge, and is released so that it reads 1 again by 45 µs.
- R7: In a slot that starts with `tx_mode`=1 and `tx_bit`=1, `pull_low` stays 0 for the whole slot.
- R8: Each slot that starts with `tx_mode`=1 gives exactly one `tx_request` pulse at its start and no `rx_valid`.
- R9: A low that exceeds 480 µs inside a read or write slot overrides the slot and is handled as a reset (R3, R4). A write slot may already have reported a 0 bit, which the upper layer discards on `reset_detected`.
- R10: `rx_valid`, `tx_request` and `reset_detected` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw bus line level (asynchronous) |
| tx_mode | input | 1 | 1: the next slot is a read slot driven by this block |
| tx_bit | input | 1 | Bit sent in the next read slot |
| pull_low | output | 1 | Open-drain pull-down enable for the pad |
| rx_valid | output | 1 | One-cycle strobe: a written bit is on `rx_bit` |
| rx_bit | output | 1 | Last bit sampled in a write slot |
| tx_request | output | 1 | One-cycle strobe: `tx_bit` was consumed and the next bit may be presented |
| reset_detected | output | 1 | One-cycle strobe: a reset pulse was recognised |

## Verification
The hardest case to reach from the ports is a reset that cuts into a read slot. For that case the block is itself pulling the line low with a 0 bit when the master keeps the line low past the reset limit. The reset timer must therefore run through the block's own drive phase. The bench reaches it with `tx_mode`=1 and `tx_bit`=0, holding the master low for 500 µs. It then measures the presence pulse that follows. Beside this, random write and read slots are issued with spec-legal low times and slot lengths. A sub-microsecond glitch probes the filter.

// File: rtl/ow_phy_pkg.sv
`timescale 1ns/1ps
package ow_phy_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SLOT_LOW,
        S_READ_HOLD,
        S_SLOT_WAIT,
        S_RST_HIGH,
        S_PRES_WAIT,
        S_PRES_DRIVE
    } ow_state_e;
endpackage

// File: rtl/ow_us_tick.sv
`timescale 1ns/1ps
module ow_us_tick #(
    parameter int CYC_PER_US = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(CYC_PER_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (CYC_PER_US > 1) begin : g_spacing
            // R5: the sample timing relies on ticks that are never back to back
            a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ow_line_filter.sv
`timescale 1ns/1ps
module ow_line_filter #(
    parameter int CYC_PER_US = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_hi
);
    localparam int CW = $clog2(CYC_PER_US + 1);

    logic          sync1_q, sync2_q;
    logic [CW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            line_hi <= 1'b1;
            hold_q  <= '0;
        end else begin
            sync1_q <= line_raw;
            sync2_q <= sync1_q;
            if (sync2_q == line_hi) begin
                hold_q <= '0;
            end else if (hold_q == CW'(CYC_PER_US - 1)) begin
                line_hi <= sync2_q;
                hold_q  <= '0;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    // R2: a filtered level change only follows a synchronised level equal to it
    a_r2_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_hi) |-> ($past(sync2_q) == line_hi));
endmodule

// File: rtl/ow_slot_fsm.sv
`timescale 1ns/1ps
module ow_slot_fsm
    import ow_phy_pkg::*;
#(
    parameter int SAMPLE_US    = 30,
    parameter int HOLD0_US     = 30,
    parameter int PRES_WAIT_US = 30,
    parameter int PRES_LEN_US  = 120,
    parameter int RESET_US     = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_hi,
    input  logic tick,
    input  logic tx_mode,
    input  logic tx_bit,
    output logic restart,
    output logic pull_low,
    output logic rx_valid,
    output logic rx_bit,
    output logic tx_request,
    output logic reset_detected
);
    localparam int CW = $clog2(RESET_US + 1);

    ow_state_e     state_q, state_n;
    logic [CW-1:0] us_q;
    logic          line_d;
    logic          fall;
    logic          ev_sample, ev_rst, ev_txreq;

    assign fall = line_d & ~line_hi;

    always_comb begin
        state_n   = state_q;
        restart   = 1'b0;
        ev_sample = 1'b0;
        ev_rst    = 1'b0;
        ev_txreq  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (fall) begin
                    restart = 1'b1;
                    if (tx_mode) begin
                        ev_txreq = 1'b1;
                        state_n  = tx_bit ? S_SLOT_WAIT : S_READ_HOLD;
                    end else begin
                        state_n = S_SLOT_LOW;
                    end
                end
            end
            S_SLOT_LOW: begin
                if (us_q == CW'(SAMPLE_US)) begin
                    ev_sample = 1'b1;
                    state_n   = S_SLOT_WAIT;
                end
            end
            S_READ_HOLD: begin
                if (us_q == CW'(HOLD0_US)) state_n = S_SLOT_WAIT;
            end
            S_SLOT_WAIT: begin
                if (us_q == CW'(RESET_US)) begin
                    ev_rst  = 1'b1;
                    state_n = S_RST_HIGH;
                end else if (line_hi) begin
                    state_n = S_IDLE;
                end
            end
            S_RST_HIGH: begin
                if (line_hi) begin
                    restart = 1'b1;
                    state_n = S_PRES_WAIT;
                end
            end
            S_PRES_WAIT: begin
                if (us_q == CW'(PRES_WAIT_US)) begin
                    restart = 1'b1;
                    state_n = S_PRES_DRIVE;
                end
            end
            S_PRES_DRIVE: begin
                if (us_q == CW'(PRES_LEN_US)) state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register and microsecond counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            us_q    <= '0;
            line_d  <= 1'b1;
        end else begin
            state_q <= state_n;
            line_d  <= line_hi;
            if (restart)                           us_q <= '0;
            else if (tick && us_q != CW'(RESET_US)) us_q <= us_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_low       <= 1'b0;
            rx_valid       <= 1'b0;
            rx_bit         <= 1'b1;
            tx_request     <= 1'b0;
            reset_detected <= 1'b0;
        end else begin
            pull_low       <= (state_n == S_READ_HOLD) || (state_n == S_PRES_DRIVE);
            rx_valid       <= ev_sample;
            tx_request     <= ev_txreq;
            reset_detected <= ev_rst;
            if (ev_sample) rx_bit <= line_hi;
        end
    end

    // R10: strobes never coincide
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, tx_request, reset_detected}));

    // R6: pulling starts only at a read-slot start or at the presence phase
    a_r6_drive_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low) |-> ($past(state_q) == S_IDLE || $past(state_q) == S_PRES_WAIT));

    // R3: reset is reported while the line is still released by this block
    a_r3_reset_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        reset_detected |-> !pull_low);

    // R8: a read-slot request is never paired with a received bit in the next cycle
    a_r8_req_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_request |=> !rx_valid);
endmodule

// File: rtl/ow_slave_phy.sv
`timescale 1ns/1ps
module ow_slave_phy #(
    parameter int CYC_PER_US   = 4,
    parameter int SAMPLE_US    = 30,
    parameter int HOLD0_US     = 30,
    parameter int PRES_WAIT_US = 30,
    parameter int PRES_LEN_US  = 120,
    parameter int RESET_US     = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic tx_mode,
    input  logic tx_bit,
    output logic pull_low,
    output logic rx_valid,
    output logic rx_bit,
    output logic tx_request,
    output logic reset_detected
);
    logic line_hi;
    logic tick;
    logic restart;

    ow_line_filter #(.CYC_PER_US(CYC_PER_US)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (line_in),
        .line_hi  (line_hi)
    );

    ow_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    ow_slot_fsm #(
        .SAMPLE_US    (SAMPLE_US),
        .HOLD0_US     (HOLD0_US),
        .PRES_WAIT_US (PRES_WAIT_US),
        .PRES_LEN_US  (PRES_LEN_US),
        .RESET_US     (RESET_US)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_hi        (line_hi),
        .tick           (tick),
        .tx_mode        (tx_mode),
        .tx_bit         (tx_bit),
        .restart        (restart),
        .pull_low       (pull_low),
        .rx_valid       (rx_valid),
        .rx_bit         (rx_bit),
        .tx_request     (tx_request),
        .reset_detected (reset_detected)
    );
endmodule

// File: tb/test_ow_slave_phy.sv
`timescale 1ns/1ps
module test_ow_slave_phy;
    localparam int CPU = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_low = 1'b0;
    logic tx_mode = 1'b0;
    logic tx_bit = 1'b1;
    logic line_in;
    logic pull_low, rx_valid, rx_bit, tx_request, reset_detected;

    int errors = 0;
    int checks = 0;
    int n_rx = 0, n_txr = 0, n_rst = 0, n_pull = 0, n_wide = 0;
    logic last_rx = 1'b1;
    logic p_rx = 1'b0, p_txr = 1'b0, p_rst = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign line_in = ~(master_low | pull_low);

    ow_slave_phy #(.CYC_PER_US(CPU)) i_ow_slave_phy (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_in        (line_in),
        .tx_mode        (tx_mode),
        .tx_bit         (tx_bit),
        .pull_low       (pull_low),
        .rx_valid       (rx_valid),
        .rx_bit         (rx_bit),
        .tx_request     (tx_request),
        .reset_detected (reset_detected)
    );

    always @(negedge clk) begin
        if (rx_valid) begin n_rx++; last_rx = rx_bit; end
        if (tx_request) n_txr++;
        if (reset_detected) n_rst++;
        if (pull_low) n_pull++;
        if ((rx_valid && p_rx) || (tx_request && p_txr) || (reset_detected && p_rst)) n_wide++;
        if (int'(rx_valid) + int'(tx_request) + int'(reset_detected) > 1) n_wide++;
        p_rx = rx_valid; p_txr = tx_request; p_rst = reset_detected;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_us(input int us);
        repeat (us * CPU) @(negedge clk);
    endtask

    function automatic bit exp_wbit(input int low_us);
        return (low_us <= 15);
    endfunction

    task automatic write_slot(input int low_us, input int slot_us, input string req);
        int rx0;
        rx0 = n_rx;
        tx_mode = 1'b0;
        master_low = 1'b1;
        wait_us(low_us);
        master_low = 1'b0;
        wait_us(slot_us - low_us);
        check(n_rx == rx0 + 1, req, n_rx - rx0, 1);
        check(last_rx == exp_wbit(low_us), req, int'(last_rx), int'(exp_wbit(low_us)));
    endtask

    task automatic read_slot(input bit b, input int low_us);
        int rx0, tr0, pl0;
        rx0 = n_rx; tr0 = n_txr; pl0 = n_pull;
        tx_mode = 1'b1;
        tx_bit = b;
        master_low = 1'b1;
        wait_us(low_us);
        master_low = 1'b0;
        wait_us(20 - low_us);
        check(line_in == b, b ? "R7 line at 20us" : "R6 line at 20us", int'(line_in), int'(b));
        wait_us(25);
        check(line_in == 1'b1, "R6 line released by 45us", int'(line_in), 1);
        wait_us(25);
        tx_mode = 1'b0;
        check(n_txr == tr0 + 1, "R8 tx_request count", n_txr - tr0, 1);
        check(n_rx == rx0, "R8 no rx_valid in read slot", n_rx - rx0, 0);
        if (b) check(n_pull == pl0, "R7 no pull for 1", n_pull - pl0, 0);
    endtask

    task automatic reset_seq(input int low_us, input bit in_read, input string req);
        int rs0, d, w;
        rs0 = n_rst;
        if (in_read) begin tx_mode = 1'b1; tx_bit = 1'b0; end
        master_low = 1'b1;
        wait_us(low_us);
        check(n_rst == rs0 + 1, req, n_rst - rs0, 1);
        master_low = 1'b0;
        tx_mode = 1'b0;
        d = 0;
        while (!pull_low && d < 200 * CPU) begin @(negedge clk); d++; end
        w = 0;
        while (pull_low && w < 400 * CPU) begin @(negedge clk); w++; end
        check(d / CPU >= 15 && d / CPU < 60, "R4 presence delay us", d / CPU, 30);
        check(w / CPU >= 60 && w / CPU < 240, "R4 presence width us", w / CPU, 120);
        wait_us(20);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd20251);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_us(10);
        // R1: reset state
        check(pull_low == 1'b0, "R1 pull_low after reset", int'(pull_low), 0);
        check(n_rx + n_txr + n_rst == 0, "R1 no strobes after reset", n_rx + n_txr + n_rst, 0);

        // R3 / R4: plain reset
        reset_seq(500, 1'b0, "R3 reset_detected once");

        // R2: 0.5 us glitch
        begin
            int a, p;
            a = n_rx + n_txr + n_rst; p = n_pull;
            master_low = 1'b1;
            @(negedge clk);
            master_low = 1'b0;
            wait_us(100);
            check(n_rx + n_txr + n_rst == a, "R2 glitch strobes", n_rx + n_txr + n_rst - a, 0);
            check(n_pull == p, "R2 glitch pull", n_pull - p, 0);
        end

        // R5: directed write slot corners
        write_slot(1, 70, "R5 write1 1us low");
        write_slot(15, 70, "R5 write1 15us low");
        write_slot(60, 70, "R5 write0 60us low");
        write_slot(110, 120, "R5 write0 110us low");

        // R6 / R7 / R8: directed read slots
        read_slot(1'b0, 2);
        read_slot(1'b1, 2);
        read_slot(1'b0, 10);

        // R9: reset overriding a read slot holding a 0
        reset_seq(500, 1'b1, "R9 reset inside read slot");
        // R9: reset overriding a write slot
        reset_seq(490, 1'b0, "R9 reset inside write slot");

        // random mix
        for (int i = 0; i < 30; i++) begin
            bit b;
            int lo, sl;
            b = 1'($urandom % 2);
            if ($urandom % 2 == 0) begin
                lo = b ? 1 + int'($urandom % 14) : 60 + int'($urandom % 50);
                sl = (lo + 10 > 70) ? lo + 10 : 70;
                sl = sl + int'($urandom % 10);
                write_slot(lo, sl, "R5 random write");
            end else begin
                read_slot(b, 1 + int'($urandom % 10));
            end
        end

        // R10: pulse width and exclusivity over whole run
        check(n_wide == 0, "R10 strobe shape", n_wide, 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule